// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine

This block is a byte-wide SPI master that runs one programmed burst at a time. Software writes a clock divider, a total byte count and a transmit byte count. It fills a 128-byte transmit FIFO through a data word and then sets a start bit. The engine drives SCK in any of the four clock modes and shifts each byte MSB-first or LSB-first. It drives one of four chip-select lines and collects the returned bytes into a 128-byte receive FIFO. When the last byte has been clocked, it raises a completion flag, which can also drive the interrupt line.

Software reaches the block through a flat register port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. A read of the receive data word removes one byte from the receive FIFO at the edge where `reg_rd` is high. Register words, selected by `reg_addr`:

| Word | Name |
|------|------|
| 0 | global control |
| 1 | transfer control |
| 2 | interrupt enable |
| 3 | status |
| 4 | FIFO control |
| 5 | FIFO status |
| 6 | clock divider |
| 7 | burst count |
| 8 | transmit count |
| 9 | transmit data |
| 10 | receive data |

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset these all read zero: the status word, the FIFO status word and the transfer control word. SCK is low, all four chip-select lines are low and `irq` is low.
- R2: Writing transfer control with bit 31 set starts a burst when all three hold: global control bit 0 (bus enable) is 1, global control bit 1 (master) is 1, and the burst count is not zero. Bit 31 reads 1 while the burst runs. It returns to 0 on the edge that completes the last byte, and status bit 12 is set on that same edge.
- R3: Transfer control bit 1 sets the idle level of SCK. Bit 0 selects the edge on which data is captured: 0 means the leading edge, 1 means the trailing edge. MOSI changes only on the other edge. Each SCK half period lasts (clock divider + 1) clock cycles.
- R4: Transfer control bit 12 set sends and receives each byte LSB first. Clear sends and receives MSB first.
- R5: The 24-bit burst count (word 7) sets how many bytes are clocked. The 24-bit transmit count (word 8) sets how many of those bytes are taken from the transmit FIFO. Every later byte of the burst is sent as 0x00.
- R6: Each byte received is appended to the receive FIFO unless transfer control bit 8 (receive discard) is set. Reading word 10 returns the oldest byte and removes it.
- R7: A byte received while the receive FIFO holds 128 bytes is dropped, and status bit 8 (overflow) is set.
- R8: FIFO status holds the receive fill level in bits 7:0 and the transmit fill level in bits 23:16, each counting 0 to 128. Writing word 9 appends its low byte to the transmit FIFO.
- R9: Writing FIFO control with bit 15 set empties the receive FIFO. Writing it with bit 31 set empties the transmit FIFO.
- R10: Writing a 1 to status bit 12 or bit 8 clears that bit. `irq` is high exactly when a status bit is set and the same bit is set in the interrupt enable word.
- R11: Transfer control bits 5:4 pick one of four chip-select lines. Bit 2 set makes the lines active low. With manual mode off, the selected line is active only while a burst runs, and the unselected lines always sit at the inactive level.
- R12: With transfer control bit 6 (manual) set, the selected line takes the value of bit 7 directly. The other three lines stay at the inactive level.
- R13: While global control bit 0 is 0, SCK stays at its idle level and a start request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Read strobe; pops the receive FIFO at word 10 |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
The assertions assume that software does not rewrite the mode bits, the divider or the counts while a burst runs. They also assume that every register strobe is a single-cycle pulse aligned to the clock. The stimulus changes the clock mode only between bursts and programs the counts before each start. It loops MOSI back to MISO, so the received bytes equal the transmitted ones in every clock mode. Receive FIFO reads happen only while no burst is running, so the overflow and fill checks see a stable FIFO.

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 24,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [3:0] W_GCTL = 4'd0, W_XCTL = 4'd1, W_IEN = 4'd2, W_STAT = 4'd3,
                         W_FCTL = 4'd4, W_FSTA = 4'd5, W_DIV = 4'd6, W_BURST = 4'd7,
                         W_TXN = 4'd8, W_TXD = 4'd9, W_RXD = 4'd10;

  logic bus_en, master_q;
  logic cpha_q, cpol_q, spol_q, man_q, lvl_q, disc_q, lsb_q;
  logic [1:0] csi_q;
  logic ie_tc, ie_ovf, st_tc, st_ovf;
  logic [DIV_W-1:0] div_q, dcnt;
  logic [CNT_W-1:0] burst_q, txn_q, bytes_done, sent;

  logic [7:0] tmem [DEPTH];
  logic [7:0] rmem [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [LW-1:0] tcnt, rcnt;

  logic run_q, sck_lvl;
  logic [3:0] edge_n;
  logic [7:0] tsh, rsh, rx_next, t_byte;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[30:24], reg_wdata[14:13], reg_wdata[11:9], reg_wdata[3]};

  wire wr_x   = reg_wr && reg_addr == W_XCTL;
  wire go     = wr_x && reg_wdata[31] && !run_q && bus_en && master_q && burst_q != '0;
  wire tick   = run_q && bus_en && dcnt == div_q;
  wire samp   = tick && (edge_n[0] == cpha_q);
  wire shft   = tick && (cpha_q ? (!edge_n[0] && edge_n != 4'd0) : (edge_n[0] && edge_n != 4'd15));
  wire b_end  = tick && edge_n == 4'd15;
  wire last   = b_end && (bytes_done + 1'b1 == burst_q);
  wire load   = go || (b_end && !last);
  wire need_tx = load && ((go ? '0 : sent) < txn_q);
  wire t_pop  = need_tx && tcnt != '0;
  wire t_push = reg_wr && reg_addr == W_TXD && tcnt != FULL;
  wire t_flush = reg_wr && reg_addr == W_FCTL && reg_wdata[31];
  wire r_try  = b_end && !disc_q;
  wire r_push = r_try && rcnt != FULL;
  wire ovf_set = r_try && rcnt == FULL;
  wire r_pop  = reg_rd && reg_addr == W_RXD && rcnt != '0;
  wire r_flush = reg_wr && reg_addr == W_FCTL && reg_wdata[15];
  wire w_stat = reg_wr && reg_addr == W_STAT;

  assign t_byte  = t_pop ? tmem[trp] : 8'h00;
  assign rx_next = samp ? (lsb_q ? {miso, rsh[7:1]} : {rsh[6:0], miso}) : rsh;
  assign mosi    = lsb_q ? tsh[0] : tsh[7];
  assign sck     = cpol_q ^ (run_q & bus_en & sck_lvl);
  assign irq     = (st_tc & ie_tc) | (st_ovf & ie_ovf);

  always_comb begin
    cs_o = {4{spol_q}};
    cs_o[csi_q] = man_q ? lvl_q : (spol_q ^ run_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_en <= 1'b0; master_q <= 1'b0;
      cpha_q <= 1'b0; cpol_q <= 1'b0; spol_q <= 1'b0; man_q <= 1'b0;
      lvl_q <= 1'b0; disc_q <= 1'b0; lsb_q <= 1'b0; csi_q <= 2'd0;
      ie_tc <= 1'b0; ie_ovf <= 1'b0;
      div_q <= '0; burst_q <= '0; txn_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        W_GCTL: begin bus_en <= reg_wdata[0]; master_q <= reg_wdata[1]; end
        W_XCTL: begin
          cpha_q <= reg_wdata[0]; cpol_q <= reg_wdata[1]; spol_q <= reg_wdata[2];
          csi_q <= reg_wdata[5:4]; man_q <= reg_wdata[6]; lvl_q <= reg_wdata[7];
          disc_q <= reg_wdata[8]; lsb_q <= reg_wdata[12];
        end
        W_IEN:   begin ie_tc <= reg_wdata[12]; ie_ovf <= reg_wdata[8]; end
        W_DIV:   div_q <= reg_wdata[DIV_W-1:0];
        W_BURST: burst_q <= reg_wdata[CNT_W-1:0];
        W_TXN:   txn_q <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_tc <= 1'b0; st_ovf <= 1'b0;
    end else begin
      if (last) st_tc <= 1'b1;
      else if (w_stat && reg_wdata[12]) st_tc <= 1'b0;
      if (ovf_set) st_ovf <= 1'b1;
      else if (w_stat && reg_wdata[8]) st_ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (t_push) tmem[twp] <= reg_wdata[7:0];
    if (r_push) rmem[rwp] <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (t_flush) begin
        twp <= '0; trp <= '0; tcnt <= '0;
      end else begin
        if (t_push) twp <= twp + 1'b1;
        if (t_pop)  trp <= trp + 1'b1;
        tcnt <= tcnt + LW'(t_push) - LW'(t_pop);
      end
      if (r_flush) begin
        rwp <= '0; rrp <= '0; rcnt <= '0;
      end else begin
        if (r_push) rwp <= rwp + 1'b1;
        if (r_pop)  rrp <= rrp + 1'b1;
        rcnt <= rcnt + LW'(r_push) - LW'(r_pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; sck_lvl <= 1'b0; dcnt <= '0; edge_n <= 4'd0;
      tsh <= 8'h00; rsh <= 8'h00; bytes_done <= '0; sent <= '0;
    end else if (go) begin
      run_q <= 1'b1; sck_lvl <= 1'b0; dcnt <= '0; edge_n <= 4'd0;
      tsh <= t_byte; rsh <= 8'h00; bytes_done <= '0;
      sent <= need_tx ? CNT_W'(1) : '0;
    end else if (run_q && bus_en) begin
      if (tick) begin
        dcnt <= '0;
        sck_lvl <= ~sck_lvl;
        edge_n <= edge_n + 4'd1;
        rsh <= rx_next;
        if (shft) tsh <= lsb_q ? (tsh >> 1) : (tsh << 1);
        if (b_end) begin
          bytes_done <= bytes_done + 1'b1;
          if (last) run_q <= 1'b0;
          else begin
            tsh <= t_byte;
            sent <= sent + CNT_W'(need_tx);
          end
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      W_GCTL: reg_rdata[1:0] = {master_q, bus_en};
      W_XCTL: begin
        reg_rdata[0] = cpha_q; reg_rdata[1] = cpol_q; reg_rdata[2] = spol_q;
        reg_rdata[5:4] = csi_q; reg_rdata[6] = man_q; reg_rdata[7] = lvl_q;
        reg_rdata[8] = disc_q; reg_rdata[12] = lsb_q; reg_rdata[31] = run_q;
      end
      W_IEN:  begin reg_rdata[12] = ie_tc; reg_rdata[8] = ie_ovf; end
      W_STAT: begin reg_rdata[12] = st_tc; reg_rdata[8] = st_ovf; end
      W_FSTA: begin reg_rdata[LW-1:0] = rcnt; reg_rdata[16 +: LW] = tcnt; end
      W_DIV:   reg_rdata = 32'(div_q);
      W_BURST: reg_rdata = 32'(burst_q);
      W_TXN:   reg_rdata = 32'(txn_q);
      W_RXD:   reg_rdata[7:0] = (rcnt != '0) ? rmem[rrp] : 8'h00;
      default: ;
    endcase
  end

  assert_sck_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> sck == cpol_q);
  assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> st_tc);
  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= FULL && rcnt <= FULL);
  assert_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && disc_q && $past(run_q && disc_q)) |-> rcnt <= $past(rcnt));
  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> st_ovf);
  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ {4{spol_q}}));
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_end && !last && sent >= txn_q) |=> tsh == 8'h00);
endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic irq, sck, mosi, miso;
  logic [3:0] cs_o;

  always #2 clk = ~clk;
  assign miso = mosi;

  spi_xfer_engine dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_o(cs_o));

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic mon_en = 1'b0, cfg_cpha = 1'b0, cfg_cpol = 1'b0, cfg_lsb = 1'b0;
  logic sck_prev = 1'b0, mosi_prev = 1'b0;
  logic [7:0] mon_byte = 8'h00;
  int mon_n = 0;
  logic [31:0] d;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    wr(4'd9, {24'h0, b});
    exp_q.push_back(b);
  endtask

  task automatic start(input logic [31:0] xc, input int burst, input int txn);
    wr(4'd1, xc);
    cfg_cpha = xc[0]; cfg_cpol = xc[1]; cfg_lsb = xc[12];
    repeat (2) @(negedge clk);
    wr(4'd7, burst);
    wr(4'd8, txn);
    mon_en = 1'b1; mon_n = 0;
    wr(4'd1, xc | 32'h8000_0000);
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int n = 0;
    s = 32'h0;
    while (s[12] !== 1'b1 && n < 20000) begin rd(4'd3, s); n++; end
    chk(req, "completion flag", {31'h0, s[12]}, 32'h1);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    chk(req, "scoreboard drained", exp_q.size(), 0);
  endtask

  // monitor: rebuilds MOSI bytes on the capture edge and compares against the queue (R3, R4, R5)
  always @(negedge clk) begin
    if (mon_en && sck !== sck_prev && (((sck != cfg_cpol)) ^ cfg_cpha)) begin
      mon_byte = cfg_lsb ? {mosi_prev, mon_byte[7:1]} : {mon_byte[6:0], mosi_prev};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk("R5", "unexpected mosi byte", {24'h0, mon_byte}, 32'hxxxx_xxxx);
        else chk("R3/R4 R5", "mosi byte", {24'h0, mon_byte}, {24'h0, exp_q.pop_front()});
      end
    end
    sck_prev = sck;
    mosi_prev = mosi;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd3, d); chk("R1", "status", d, 0);
    rd(4'd5, d); chk("R1", "fifo status", d, 0);
    rd(4'd1, d); chk("R1", "transfer control", d, 0);
    chk("R1", "pins sck/cs/irq", {26'h0, sck, irq, cs_o}, 0);

    wr(4'd0, 32'h3);
    wr(4'd6, 32'd1);

    // mode 0, MSB first
    push_tx(8'hA5); push_tx(8'h3C); push_tx(8'h81);
    rd(4'd5, d); chk("R8", "tx fill level", {24'h0, d[23:16]}, 3);
    start(32'h0, 3, 3);
    rd(4'd1, d); chk("R2", "start bit while busy", {31'h0, d[31]}, 1);
    wait_done("R2");
    rd(4'd1, d); chk("R2", "start bit cleared", {31'h0, d[31]}, 0);
    rd(4'd5, d); chk("R8", "rx fill level", {24'h0, d[7:0]}, 3);
    chk("R8", "tx drained", {24'h0, d[23:16]}, 0);
    rd(4'd10, d); chk("R6", "rx byte 0", d, 32'hA5);
    rd(4'd10, d); chk("R6", "rx byte 1", d, 32'h3C);
    rd(4'd10, d); chk("R6", "rx byte 2", d, 32'h81);
    wr(4'd3, 32'h1100);

    // mode 3, LSB first, line 2 active low, divider 2
    wr(4'd6, 32'd2);
    wr(4'd1, 32'h1027);
    repeat (3) @(negedge clk);
    chk("R11", "idle lines high", {28'h0, cs_o}, 32'hF);
    chk("R3", "sck idle high", {31'h0, sck}, 1);
    push_tx(8'h4E); push_tx(8'hD1); push_tx(8'h07);
    start(32'h1027, 3, 3);
    begin
      logic v;
      int n = 0;
      while (sck == 1'b1) @(negedge clk);
      v = sck;
      do begin @(negedge clk); n++; end while (sck == v);
      chk("R3", "sck half period", n, 3);
    end
    chk("R11", "line 2 active", {28'h0, cs_o}, 32'hB);
    wait_done("R4");
    chk("R11", "line released", {28'h0, cs_o}, 32'hF);
    rd(4'd10, d); chk("R4", "rx byte 0", d, 32'h4E);
    rd(4'd10, d); chk("R4", "rx byte 1", d, 32'hD1);
    rd(4'd10, d); chk("R4", "rx byte 2", d, 32'h07);
    wr(4'd3, 32'h1100);

    // transmit count shorter than burst
    wr(4'd6, 32'd1);
    push_tx(8'h11); push_tx(8'h22);
    exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    start(32'h0, 4, 2);
    wait_done("R5");
    rd(4'd5, d); chk("R5", "rx count", {24'h0, d[7:0]}, 4);
    rd(4'd10, d); chk("R5", "byte 0", d, 32'h11);
    rd(4'd10, d); chk("R5", "byte 1", d, 32'h22);
    rd(4'd10, d); chk("R5", "zero byte 2", d, 0);
    rd(4'd10, d); chk("R5", "zero byte 3", d, 0);
    wr(4'd3, 32'h1100);

    // receive discard
    push_tx(8'h5A);
    start(32'h100, 1, 1);
    wait_done("R6");
    rd(4'd5, d); chk("R6", "discard leaves rx empty", {24'h0, d[7:0]}, 0);
    wr(4'd3, 32'h1100);

    // overflow and interrupt gating
    wr(4'd2, 32'h1000);
    for (int i = 0; i < 130; i++) exp_q.push_back(8'h00);
    start(32'h0, 130, 0);
    wait_done("R7");
    rd(4'd5, d); chk("R8", "rx full level 128", {24'h0, d[7:0]}, 128);
    rd(4'd3, d); chk("R7", "status flags", d, 32'h1100);
    chk("R10", "irq tc enabled", {31'h0, irq}, 1);
    wr(4'd3, 32'h1000);
    rd(4'd3, d); chk("R10", "w1c tc only", d, 32'h0100);
    chk("R10", "irq ovf masked", {31'h0, irq}, 0);
    wr(4'd2, 32'h0100);
    chk("R10", "irq ovf enabled", {31'h0, irq}, 1);
    wr(4'd3, 32'h0100);
    chk("R10", "irq after clear", {31'h0, irq}, 0);

    // flushes
    wr(4'd4, 32'h8000);
    rd(4'd5, d); chk("R9", "rx flushed", {24'h0, d[7:0]}, 0);
    for (int i = 0; i < 5; i++) wr(4'd9, i);
    rd(4'd5, d); chk("R9", "tx before flush", {24'h0, d[23:16]}, 5);
    wr(4'd4, 32'h8000_0000);
    rd(4'd5, d); chk("R9", "tx flushed", {24'h0, d[23:16]}, 0);

    // bus disabled
    wr(4'd0, 32'h2);
    wr(4'd7, 32'd1);
    wr(4'd1, 32'h8000_0000);
    rd(4'd1, d); chk("R13", "start ignored", {31'h0, d[31]}, 0);
    repeat (20) @(negedge clk);
    chk("R13", "sck idle", {31'h0, sck}, 0);
    rd(4'd3, d); chk("R13", "no completion", d, 0);
    wr(4'd0, 32'h3);

    // manual chip select
    wr(4'd1, 32'h00D0);
    @(negedge clk); chk("R12", "manual level 1 on line 1", {28'h0, cs_o}, 32'h2);
    wr(4'd1, 32'h0050);
    @(negedge clk); chk("R12", "manual level 0 on line 1", {28'h0, cs_o}, 32'h0);
    wr(4'd1, 32'h0074);
    @(negedge clk); chk("R12", "active-low line 3 low", {28'h0, cs_o}, 32'h7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule